// File: doc/BRIEF.md
# Data-Out Transfer Counter with Staging-Buffer Flush

This block runs the host-to-target data-out phase of a SCSI controller. Software first writes a start count, one byte at a time, into three byte-wide count registers. It then pulses `start` together with the total number of bytes the target expects. From that point the block accepts host bytes into an internal staging buffer and counts down both the transfer count and the remaining total. Each time enough bytes have gathered, it hands the buffer to the target side through a valid/ready flush handshake.

Each flush raises an interrupt and a service request. When both the transfer count and the remaining total run out, the phase moves to status. The target side reads the staged bytes through a synchronous read port while the flush request is pending.

The control is a three-state machine:
- `S_IDLE`: no transfer is active.
- `S_ACTIVE`: bytes are being accepted.
- `S_FLUSH`: a flush is offered and host writes are held off.

Its transitions are:
- `S_IDLE`→`S_ACTIVE` on start.
- `S_ACTIVE`→`S_ACTIVE` on a restart, which reloads the counters.
- `S_ACTIVE`→`S_FLUSH` when a flush condition is hit.
- `S_FLUSH`→`S_ACTIVE` when the handshake completes while the phase is still data-out.
- `S_FLUSH`→`S_IDLE` when the handshake completes after the transfer has ended.

Top module: `dout_xfer_engine`

## Requirements
- R1: After reset the status byte reads 0x13 (bit 7 interrupt = 0, bit 4 count-zero = 1, bits 2:0 phase = 3, the status phase), irq is low, the transfer count and remaining total are 0, flush_valid is low and wr_ready is high.
- R2: The start count is assembled from three byte registers: cfg_sel 0 is the low byte, 1 the middle byte and 2 the high byte (cfg_sel 3 writes nothing). A `start` pulse copies the assembled value into the transfer count and start_total into the remaining total.
- R3: A start count of zero loads the transfer count as 65536 (0x010000).
- R4: `start` sets the phase to data-out (code 0), clears the count-zero bit and returns the buffer offset to 0.
- R5: Each accepted byte is stored at the current buffer offset and can be read one cycle after rd_addr is applied. The offset then increments, the transfer count decrements, and the remaining total decrements, stopping at 0.
- R6: The flush threshold is the smaller of the loaded count and 2048. A flush is offered when the offset reaches the threshold or the transfer count reaches zero, and flush_len carries the number of buffered bytes.
- R7: On every flush, irq and srv_req are set and every status bit other than the interrupt and the phase reads 0.
- R8: When a write leaves both the transfer count and the remaining total at zero, the status byte becomes 0x83 (interrupt together with the status phase).
- R9: While flush_valid is high, wr_ready is low and flush_len is stable. The handshake completes on flush_ready, after which the next byte is stored at offset 0.
- R10: A byte offered while the transfer count is zero, or while no transfer is active, changes neither the counters nor the buffer, and offers no flush.
- R11: irq_ack clears the interrupt bit, irq and srv_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Start-count register write strobe |
| cfg_sel | input | 2 | Start-count byte select: 0 low, 1 middle, 2 high |
| cfg_wdata | input | 8 | Start-count byte value |
| start | input | 1 | Begin a data-out transfer (load strobe) |
| start_total | input | 24 | Total bytes expected by the target |
| wr_valid | input | 1 | Host byte offered |
| wr_data | input | 8 | Host byte |
| wr_ready | output | 1 | Low while a flush is pending |
| flush_valid | output | 1 | Buffer flush offered to the target side |
| flush_len | output | 12 | Number of bytes in the flushed buffer |
| flush_ready | input | 1 | Target side accepts the flush |
| rd_addr | input | 11 | Staging buffer read address |
| rd_data | output | 8 | Staging buffer byte, one cycle after rd_addr |
| xfer_count | output | 24 | Current transfer count |
| total_left | output | 24 | Current remaining total |
| status | output | 8 | Bit 7 interrupt, bit 4 count-zero, bits 2:0 phase |
| srv_req | output | 1 | Service-request flag |
| irq | output | 1 | Interrupt line |
| irq_ack | input | 1 | Clears interrupt and service request |

## Verification
The main function is driven with four count patterns, and each one separates a different flush cause:
- A short count equal to the total ends the transfer on its own flush, which separates an end flush from an intermediate one.
- A zero count runs past the 2048-byte buffer limit, which separates the threshold flush from a count-exhausted flush and checks the 65536 substitution.
- A short count with a larger total separates exhaustion of the count from the end of the transfer.
- A count larger than its total checks that the total saturates and that the end is still detected.

A count built from three distinct bytes exposes any byte swap in assembly. Writes offered during a pending flush, after exhaustion and while idle show whether ignored traffic leaks into the counters or the buffer.

// File: rtl/dout_pkg.sv
`timescale 1ns/1ps
package dout_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ACTIVE = 2'd1,
        S_FLUSH  = 2'd2
    } dout_state_e;

    localparam logic [2:0] PH_DATA_OUT = 3'd0;
    localparam logic [2:0] PH_STATUS   = 3'd3;
    localparam int         ST_INTR     = 7;
    localparam int         ST_CZERO    = 4;
endpackage

// File: rtl/dout_counters.sv
`timescale 1ns/1ps
module dout_counters #(
    parameter int CNT_W     = 24,
    parameter int DATA_W    = 8,
    parameter int BUF_DEPTH = 2048,
    parameter int ZERO_SUB  = 65536,
    localparam int NB       = CNT_W / DATA_W,
    localparam int SEL_W    = $clog2(NB),
    localparam int OFF_W    = $clog2(BUF_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_total,
    input  logic              dec,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  total,
    output logic [OFF_W-1:0]  thresh
);
    logic [NB-1:0][DATA_W-1:0] start_q;
    logic [CNT_W-1:0]          eff;

    // One register per byte lane of the start count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < NB; i++) begin
                if (cfg_sel == SEL_W'(i)) start_q[i] <= cfg_wdata;
            end
        end
    end

    // A zero start count means the substitute value.
    always_comb begin
        eff = CNT_W'(start_q);
        if (eff == '0) eff = CNT_W'(ZERO_SUB);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            total  <= '0;
            thresh <= OFF_W'(BUF_DEPTH);
        end else if (load) begin
            count  <= eff;
            total  <= load_total;
            thresh <= (eff < CNT_W'(BUF_DEPTH)) ? OFF_W'(eff) : OFF_W'(BUF_DEPTH);
        end else if (dec) begin
            count <= count - CNT_W'(1);
            if (total != '0) total <= total - CNT_W'(1);
        end
    end
endmodule

// File: rtl/dout_stagebuf.sv
`timescale 1ns/1ps
module dout_stagebuf #(
    parameter int DATA_W    = 8,
    parameter int BUF_DEPTH = 2048,
    localparam int ADDR_W   = $clog2(BUF_DEPTH),
    localparam int OFF_W    = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              put,
    input  logic [DATA_W-1:0] din,
    input  logic              clr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [OFF_W-1:0]  off
);
    logic [DATA_W-1:0] mem [BUF_DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    off <= '0;
        else if (clr)  off <= '0;
        else if (put)  off <= off + OFF_W'(1);
    end

    always_ff @(posedge clk) begin
        if (put) mem[off[ADDR_W-1:0]] <= din;
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/dout_xfer_engine.sv
`timescale 1ns/1ps
module dout_xfer_engine
    import dout_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int DATA_W    = 8,
    parameter int BUF_DEPTH = 2048,
    parameter int ZERO_SUB  = 65536,
    localparam int ADDR_W   = $clog2(BUF_DEPTH),
    localparam int OFF_W    = ADDR_W + 1,
    localparam int SEL_W    = $clog2(CNT_W / DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              start,
    input  logic [CNT_W-1:0]  start_total,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              flush_valid,
    output logic [OFF_W-1:0]  flush_len,
    input  logic              flush_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  xfer_count,
    output logic [CNT_W-1:0]  total_left,
    output logic [7:0]        status,
    output logic              srv_req,
    output logic              irq,
    input  logic              irq_ack
);
    dout_state_e      state_q, state_d;
    logic             intr_q, srv_q, cz_q;
    logic [2:0]       phase_q;
    logic [OFF_W-1:0] flen_q, off, thr, new_off;
    logic             start_acc, acc, flush_hit, end_hit, flush_done;

    assign start_acc  = start && (state_q != S_FLUSH);
    assign acc        = (state_q == S_ACTIVE) && wr_valid && !start && (xfer_count != '0);
    assign new_off    = off + OFF_W'(1);
    assign flush_hit  = acc && ((new_off == thr) || (xfer_count == CNT_W'(1)));
    assign end_hit    = acc && (xfer_count == CNT_W'(1)) && (total_left <= CNT_W'(1));
    assign flush_done = (state_q == S_FLUSH) && flush_ready;

    dout_counters #(
        .CNT_W(CNT_W), .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH), .ZERO_SUB(ZERO_SUB)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .load(start_acc), .load_total(start_total), .dec(acc),
        .count(xfer_count), .total(total_left), .thresh(thr)
    );

    dout_stagebuf #(
        .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH)
    ) u_buf (
        .clk(clk), .rst_n(rst_n),
        .put(acc), .din(wr_data), .clr(start_acc || flush_done),
        .rd_addr(rd_addr), .rd_data(rd_data), .off(off)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_acc) state_d = S_ACTIVE;
            S_ACTIVE: if (start_acc) state_d = S_ACTIVE;
                      else if (flush_hit) state_d = S_FLUSH;
            S_FLUSH:  if (flush_ready) state_d = (phase_q == PH_STATUS) ? S_IDLE : S_ACTIVE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Status and flush-length registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            intr_q  <= 1'b0;
            srv_q   <= 1'b0;
            cz_q    <= 1'b1;
            phase_q <= PH_STATUS;
            flen_q  <= '0;
        end else begin
            if (irq_ack) begin
                intr_q <= 1'b0;
                srv_q  <= 1'b0;
            end
            if (start_acc) begin
                cz_q    <= 1'b0;
                phase_q <= PH_DATA_OUT;
            end
            if (flush_hit) begin
                intr_q <= 1'b1;
                srv_q  <= 1'b1;
                cz_q   <= 1'b0;
                flen_q <= new_off;
            end
            if (end_hit) phase_q <= PH_STATUS;
        end
    end

    // Outputs
    always_comb begin
        wr_ready          = (state_q != S_FLUSH);
        flush_valid       = (state_q == S_FLUSH);
        flush_len         = flen_q;
        status            = 8'h00;
        status[ST_INTR]   = intr_q;
        status[ST_CZERO]  = cz_q;
        status[2:0]       = phase_q;
        srv_req           = srv_q;
        irq               = intr_q;
    end
endmodule

// File: rtl/dout_xfer_engine_chk.sv
`timescale 1ns/1ps
module dout_xfer_engine_chk #(
    parameter int CNT_W     = 24,
    parameter int BUF_DEPTH = 2048,
    parameter int OFF_W     = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic             flush_valid,
    input logic [OFF_W-1:0] flush_len,
    input logic             flush_ready,
    input logic [CNT_W-1:0] xfer_count,
    input logic [CNT_W-1:0] total_left,
    input logic [7:0]       status,
    input logic             srv_req,
    input logic             irq
);
    // R9: host writes are held off while a flush is offered
    p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> !wr_ready);

    // R9: a pending flush stays offered with an unchanged length
    p_flush_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && !flush_ready) |=> (flush_valid && $stable(flush_len)));

    // R5: an accepted byte lowers the count by one
    p_count_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !start && status[2:0] == 3'd0 && xfer_count != '0)
        |=> xfer_count == $past(xfer_count) - CNT_W'(1));

    // R10: an exhausted count stays at zero until the next start
    p_zero_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_count == '0 && !start) |=> xfer_count == '0);

    // R7: a new flush comes with interrupt and service request
    p_flush_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_valid) |-> (irq && srv_req && !status[4]));

    // R6: the flush length lies within the buffer
    p_len_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> (flush_len != '0 && flush_len <= OFF_W'(BUF_DEPTH)));

    // R8: a flush in the status phase means both counters are spent
    p_end_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && status[2:0] == 3'd3) |-> (xfer_count == '0 && total_left == '0));
endmodule

bind dout_xfer_engine dout_xfer_engine_chk #(
    .CNT_W(CNT_W), .BUF_DEPTH(BUF_DEPTH), .OFF_W(OFF_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .flush_valid(flush_valid), .flush_len(flush_len), .flush_ready(flush_ready),
    .xfer_count(xfer_count), .total_left(total_left), .status(status),
    .srv_req(srv_req), .irq(irq)
);

// File: tb/dout_xfer_engine_test.sv
`timescale 1ns/1ps
module dout_xfer_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        start = 1'b0;
    logic [23:0] start_total = '0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wr_ready, flush_valid, flush_ready = 1'b0;
    logic [11:0] flush_len;
    logic [10:0] rd_addr = '0;
    logic [7:0]  rd_data, status;
    logic [23:0] xfer_count, total_left;
    logic        srv_req, irq, irq_ack = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    dout_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .start(start), .start_total(start_total), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .flush_valid(flush_valid), .flush_len(flush_len),
        .flush_ready(flush_ready), .rd_addr(rd_addr), .rd_data(rd_data),
        .xfer_count(xfer_count), .total_left(total_left), .status(status),
        .srv_req(srv_req), .irq(irq), .irq_ack(irq_ack)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic load_count(input logic [7:0] lo, input logic [7:0] mid, input logic [7:0] hi);
        logic [7:0] b [3];
        b[0] = lo; b[1] = mid; b[2] = hi;
        for (int i = 0; i < 3; i++) begin
            cfg_we = 1'b1; cfg_sel = 2'(i); cfg_wdata = b[i];
            @(negedge clk);
        end
        cfg_we = 1'b0;
    endtask

    task automatic do_start(input int total);
        start = 1'b1; start_total = 24'(total);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] d);
        wr_valid = 1'b1; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic take_flush();
        flush_ready = 1'b1;
        @(negedge clk);
        flush_ready = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic read_buf(input int a, output logic [7:0] d);
        rd_addr = 11'(a);
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic t_reset();
        chk_eq("R1 status", status, 8'h13);
        chk_eq("R1 irq", irq, 0);
        chk_eq("R1 count", xfer_count, 0);
        chk_eq("R1 flush_valid", flush_valid, 0);
        chk_eq("R1 wr_ready", wr_ready, 1);
    endtask

    task automatic t_short_end();
        logic [7:0] d;
        load_count(8'd5, 8'd0, 8'd0);
        do_start(5);
        chk_eq("R2 count", xfer_count, 5);
        chk_eq("R2 total", total_left, 5);
        chk_eq("R4 status", status, 8'h00);
        for (int i = 0; i < 4; i++) put_byte(8'hA0 + 8'(i));
        chk_eq("R5 count", xfer_count, 1);
        chk_eq("R5 total", total_left, 1);
        chk_eq("R6 no early flush", flush_valid, 0);
        put_byte(8'hA4);
        chk_eq("R6 flush", flush_valid, 1);
        chk_eq("R6 len", flush_len, 5);
        chk_eq("R8 status", status, 8'h83);
        chk_eq("R7 srv", srv_req, 1);
        chk_eq("R9 ready low", wr_ready, 0);
        for (int i = 0; i < 5; i++) begin
            read_buf(i, d);
            chk_eq("R5 data", d, 8'hA0 + i);
        end
        take_flush();
        chk_eq("R9 flush done", flush_valid, 0);
        ack();
        chk_eq("R11 irq", irq, 0);
        chk_eq("R11 srv", srv_req, 0);
        chk_eq("R11 status", status, 8'h03);
    endtask

    task automatic t_zero_big();
        logic [7:0] d;
        load_count(8'd0, 8'd0, 8'd0);
        do_start(100000);
        chk_eq("R3 count", xfer_count, 65536);
        for (int i = 0; i < 2047; i++) put_byte(8'(i) ^ 8'h5A);
        chk_eq("R6 below thr", flush_valid, 0);
        put_byte(8'(2047) ^ 8'h5A);
        chk_eq("R6 thr flush", flush_valid, 1);
        chk_eq("R6 thr len", flush_len, 2048);
        chk_eq("R7 status", status, 8'h80);
        chk_eq("R7 srv", srv_req, 1);
        chk_eq("R5 count", xfer_count, 65536 - 2048);
        read_buf(2047, d);
        chk_eq("R5 last byte", d, 8'hFF ^ 8'h5A);
        put_byte(8'h77);
        chk_eq("R9 held count", xfer_count, 65536 - 2048);
        chk_eq("R9 held ready", wr_ready, 0);
        take_flush();
        ack();
        put_byte(8'hC3);
        chk_eq("R9 count", xfer_count, 65536 - 2049);
        read_buf(0, d);
        chk_eq("R9 offset zero", d, 8'hC3);
        read_buf(1, d);
        chk_eq("R9 next untouched", d, 8'h01 ^ 8'h5A);
    endtask

    task automatic t_assemble();
        load_count(8'h20, 8'h10, 8'h02);
        cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 8'hEE;
        @(negedge clk);
        cfg_we = 1'b0;
        do_start(1);
        chk_eq("R2 assembled", xfer_count, 24'h021020);
        chk_eq("R4 phase", status, 8'h00);
    endtask

    task automatic t_count_first();
        logic [7:0] d;
        load_count(8'd2, 8'd0, 8'd0);
        do_start(10);
        put_byte(8'h11);
        put_byte(8'h22);
        chk_eq("R6 count flush", flush_valid, 1);
        chk_eq("R6 count len", flush_len, 2);
        chk_eq("R7 status", status, 8'h80);
        chk_eq("R5 total", total_left, 8);
        take_flush();
        ack();
        put_byte(8'h99);
        chk_eq("R10 count", xfer_count, 0);
        chk_eq("R10 total", total_left, 8);
        chk_eq("R10 no flush", flush_valid, 0);
        chk_eq("R10 irq", irq, 0);
        read_buf(0, d);
        chk_eq("R10 buffer", d, 8'h11);
    endtask

    task automatic t_total_first();
        logic [7:0] d;
        load_count(8'd4, 8'd0, 8'd0);
        do_start(2);
        put_byte(8'h31);
        put_byte(8'h32);
        chk_eq("R5 total zero", total_left, 0);
        put_byte(8'h33);
        chk_eq("R5 saturate", total_left, 0);
        chk_eq("R6 none yet", flush_valid, 0);
        put_byte(8'h34);
        chk_eq("R8 status", status, 8'h83);
        chk_eq("R6 len", flush_len, 4);
        take_flush();
        put_byte(8'h55);
        chk_eq("R10 idle count", xfer_count, 0);
        chk_eq("R10 idle flush", flush_valid, 0);
        read_buf(0, d);
        chk_eq("R10 idle buffer", d, 8'h31);
        ack();
        chk_eq("R11 status", status, 8'h03);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short_end();
        t_zero_big();
        t_assemble();
        t_count_first();
        t_total_first();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule